// File: doc/BRIEF.md
# ADC Acquisition Control Sequencer

This block holds the control word for a bank of eight converters that share one conversion clock. Software writes the word through a 32-bit port with per-byte lane enables. The block decodes the word into a channel enable mask, four indicator drive bits and an 8-bit divider setting. It also produces a single sample-clock enable, `conv_en`, that gates every converter at the same instant.

The sample-clock enable works in one of two modes. In direct mode, a software run bit gates the divided sample ticks straight through. In burst mode, a 0-to-1 change of the run bit loads a counter with a programmed length of 1 to 256. The block then passes exactly that many sample ticks and stops by itself. The length field holds the sample count minus one. A `busy` output marks a burst in progress.

The divided sample tick comes from an external divider that uses `div_sel`. A write takes effect on the clock edge that samples the strobe.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset, `chan_en` is 8'hFF, `led` and `div_sel` are zero, and `busy` and `conv_en` are low even while `samp_tick` is high. The block resets to burst mode with the run bit clear.
- R2: A write with `wr_en` high updates only the byte lanes whose `wr_be` bit is set. The new values appear on the outputs in the cycle after the strobe. With `wr_en` low, or with no lane enabled, the decoded outputs do not change.
- R3: The word layout is as follows. `led` is bits 3:0. `chan_en` is bits 15:8. `div_sel` is bits 19:16 followed by bits 7:4, so `div_sel[7:4]` comes from bits 19:16 and `div_sel[3:0]` from bits 7:4. Bit 20 is the run bit. Bit 21 is the mode bit, with 1 for direct and 0 for burst. Bits 31:24 hold the burst length minus one.
- R4: In direct mode, `conv_en` equals `samp_tick` while the run bit is 1. It stays low while the run bit is 0.
- R5: In burst mode, a write that changes the run bit from 0 to 1 starts a burst. `busy` is high in the cycle after that write. `conv_en` pulses on exactly (length field + 1) sample ticks, and `busy` then drops.
- R6: A length field of 0 gives one pulse, and a length field of 8'hFF gives 256 pulses.
- R7: A 0-to-1 change of the run bit during a burst is ignored, so the pulse total is unchanged. Writing 1 to a run bit that is already 1 starts nothing.
- R8: A write that selects direct mode cancels any burst, and `busy` is low in the cycle after that write.
- R9: `conv_en` is never high without `samp_tick`. In burst mode, it is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte lane enables, where bit k covers data bits 8k+7:8k |
| wr_data | input | 32 | Control word write data |
| samp_tick | input | 1 | Divided sample tick |
| conv_en | output | 1 | Common sample-clock enable for all converters |
| busy | output | 1 | Burst in progress |
| chan_en | output | 8 | Per-channel enable mask |
| led | output | 4 | Indicator drive bits |
| div_sel | output | 8 | Clock divider setting |

## Verification
Register fields and `busy` are registered, so they are due one clock after the edge that samples `wr_en`. The bench drives every write on a falling edge, removes it on the next falling edge, and checks the outputs at that point. `conv_en` is combinational from `samp_tick` and the registered state, so it is due in the same cycle as the tick. The bench raises the tick on a falling edge and samples `conv_en` one nanosecond later, before the rising edge that advances the counter. Burst totals are counted pulse by pulse until `busy` is seen low at a sampling point.

// File: rtl/adc_acq_seq.sv
module adc_acq_seq #(
  parameter int LEN_W = 8,
  parameter int NCH   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             samp_tick,
  output logic             conv_en,
  output logic             busy,
  output logic [NCH-1:0]   chan_en,
  output logic [3:0]       led,
  output logic [7:0]       div_sel
);
  localparam int CNT_W = LEN_W + 1;

  logic [3:0]       led_q, div_lo, div_hi;
  logic [NCH-1:0]   chan_q;
  logic             run_q, mode_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;

  logic             run_nx, mode_nx, trig;
  logic [LEN_W-1:0] len_nx;
  logic             unused_ok;

  assign unused_ok = ^wr_data[23:22];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      div_lo <= '0;
      div_hi <= '0;
      chan_q <= '1;
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      len_q  <= '0;
    end else if (wr_en) begin
      if (wr_be[0]) begin
        led_q  <= wr_data[3:0];
        div_lo <= wr_data[7:4];
      end
      if (wr_be[1]) chan_q <= wr_data[8 +: NCH];
      if (wr_be[2]) begin
        div_hi <= wr_data[19:16];
        run_q  <= wr_data[20];
        mode_q <= wr_data[21];
      end
      if (wr_be[3]) len_q <= wr_data[24 +: LEN_W];
    end
  end

  assign run_nx  = (wr_en && wr_be[2]) ? wr_data[20] : run_q;
  assign mode_nx = (wr_en && wr_be[2]) ? wr_data[21] : mode_q;
  assign len_nx  = (wr_en && wr_be[3]) ? wr_data[24 +: LEN_W] : len_q;
  assign trig    = !run_q && run_nx && !mode_nx && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (mode_nx)          cnt_q <= '0;
    else if (trig)             cnt_q <= {1'b0, len_nx} + CNT_W'(1);
    else if (busy && samp_tick) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy    = |cnt_q;
  assign conv_en = samp_tick && (mode_q ? run_q : busy);
  assign chan_en = chan_q;
  assign led     = led_q;
  assign div_sel = {div_hi, div_lo};
endmodule

module adc_acq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic        samp_tick,
  input logic        conv_en,
  input logic        busy,
  input logic [7:0]  chan_en,
  input logic [3:0]  led,
  input logic [7:0]  div_sel,
  input logic        mode_q,
  input logic        run_q
);
  AST_TICK_GATE:  assert property (@(posedge clk) disable iff (!rst_n) conv_en |-> samp_tick); // R9
  AST_BURST_GATE: assert property (@(posedge clk) disable iff (!rst_n) (!mode_q && conv_en) |-> busy); // R9
  AST_DIRECT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode_q && !run_q) |-> !conv_en); // R4
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wr_en)); // R5
  AST_BUSY_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (busy && !samp_tick && !(wr_en && wr_be[2])) |=> busy); // R5
  AST_ABORT:      assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_be[2] && wr_data[21]) |=> !busy); // R8
  AST_REG_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> ($stable(chan_en) && $stable(led) && $stable(div_sel))); // R2
endmodule

bind adc_acq_seq adc_acq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .samp_tick(samp_tick), .conv_en(conv_en), .busy(busy), .chan_en(chan_en),
  .led(led), .div_sel(div_sel), .mode_q(mode_q), .run_q(run_q)
);

// File: tb/test_adc_acq_seq.sv
module test_adc_acq_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        samp_tick = 1'b0;
  logic        conv_en, busy;
  logic [7:0]  chan_en, div_sel;
  logic [3:0]  led;
  int runs = 0, fails = 0, pulses = 0;

  always #5ns clk = ~clk;

  adc_acq_seq i_adc_acq_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .samp_tick(samp_tick), .conv_en(conv_en), .busy(busy), .chan_en(chan_en),
    .led(led), .div_sel(div_sel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [7:0] len, input logic mode, input logic run,
                                       input logic [7:0] ch, input logic [7:0] dv, input logic [3:0] ld);
    return {len, 2'b00, mode, run, dv[7:4], ch, dv[3:0], ld};
  endfunction

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic tick_cycles(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      samp_tick = (i % period) == 0;
      #1ns;
      if (conv_en && !samp_tick) chk("R9", "conv_en without tick", 1, 0);
      if (conv_en) pulses++;
      @(negedge clk);
      samp_tick = 1'b0;
    end
  endtask

  task automatic drain(input int period);
    for (int i = 0; i < 4000; i++) begin
      samp_tick = (i % period) == 0;
      #1ns;
      if (!busy) begin
        samp_tick = 1'b0;
        if (conv_en) chk("R9", "conv_en after burst", 1, 0);
        return;
      end
      if (conv_en) pulses++;
      @(negedge clk);
      samp_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    samp_tick = 1'b1; #1ns;
    chk("R1", "chan_en", chan_en, 8'hFF);
    chk("R1", "led", led, 0);
    chk("R1", "div_sel", div_sel, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "conv_en", conv_en, 0);
    samp_tick = 1'b0;
  endtask

  task automatic t_lanes;
    wr(32'h1234_5678, 4'b0001);
    chk("R2", "led lane0", led, 4'h8);
    chk("R3", "div low nibble", div_sel, 8'h07);
    chk("R2", "chan untouched", chan_en, 8'hFF);
    wr(32'h0003_0000, 4'b0100);
    chk("R3", "div high nibble", div_sel, 8'h37);
    wr(32'h0000_5A00, 4'b0010);
    chk("R3", "chan_en", chan_en, 8'h5A);
    wr(32'hFFFF_FFFF, 4'b0000);
    chk("R2", "no lanes chan", chan_en, 8'h5A);
    chk("R2", "no lanes div", div_sel, 8'h37);
    chk("R2", "no lanes busy", busy, 0);
  endtask

  task automatic t_direct;
    int hits = 0;
    wr(word(8'h00, 1'b1, 1'b1, 8'hFF, 8'h00, 4'h0), 4'hF);
    for (int i = 0; i < 12; i++) begin
      samp_tick = (i % 3) != 1; #1ns;
      if (conv_en == samp_tick) hits++;
      @(negedge clk);
    end
    samp_tick = 1'b0;
    chk("R4", "direct follow count", hits, 12);
    wr(word(8'h00, 1'b1, 1'b0, 8'hFF, 8'h00, 4'h0), 4'hF);
    samp_tick = 1'b1; #1ns;
    chk("R4", "direct stopped", conv_en, 0);
    samp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_burst(input logic [7:0] len, input int period, input string req);
    wr(word(len, 1'b0, 1'b0, 8'hFF, 8'h00, 4'h0), 4'hF);
    wr(word(len, 1'b0, 1'b1, 8'hFF, 8'h00, 4'h0), 4'hF);
    chk("R5", "busy after trigger", busy, 1);
    pulses = 0;
    drain(period);
    chk(req, "burst pulse total", pulses, int'(len) + 1);
    chk("R5", "busy after burst", busy, 0);
  endtask

  task automatic t_retrig;
    wr(word(8'd9, 1'b0, 1'b0, 8'hFF, 8'h00, 4'h0), 4'hF);
    wr(word(8'd9, 1'b0, 1'b1, 8'hFF, 8'h00, 4'h0), 4'hF);
    pulses = 0;
    tick_cycles(3, 1);
    wr(32'h0000_0000, 4'b0100);
    wr(32'h0010_0000, 4'b0100);
    drain(2);
    chk("R7", "retrigger ignored total", pulses, 10);
    wr(32'h0010_0000, 4'b0100);
    chk("R7", "run already set no start", busy, 0);
  endtask

  task automatic t_abort;
    wr(word(8'd50, 1'b0, 1'b0, 8'hFF, 8'h00, 4'h0), 4'hF);
    wr(word(8'd50, 1'b0, 1'b1, 8'hFF, 8'h00, 4'h0), 4'hF);
    tick_cycles(5, 1);
    chk("R8", "busy before abort", busy, 1);
    wr(word(8'd50, 1'b1, 1'b0, 8'hFF, 8'h00, 4'h0), 4'hF);
    chk("R8", "busy after abort", busy, 0);
    samp_tick = 1'b1; #1ns;
    chk("R8", "no conv after abort", conv_en, 0);
    samp_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_direct();
    t_burst(8'h00, 1, "R6");
    t_burst(8'hFF, 1, "R6");
    t_burst(8'h04, 3, "R5");
    t_retrig();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule